// File: doc/BRIEF.md
# Self-Repairing Hamming-Coded Register File

This block is a small storage array of 4-bit words. Each word is kept as a 7-bit single-error-correcting Hamming codeword. The write port encodes data as it is stored. The read port decodes the addressed word and returns corrected data one cycle later, together with a flag that shows whether a bit had to be repaired. The stored word itself is left as it is.

A background walker visits one address every `PERIOD` cycles, in ascending order, and wraps after the last entry. At each visit it recomputes the syndrome of the stored word. When the syndrome is non-zero it writes the repaired codeword back, so that a single upset is removed before a second one can build up in the same word. Each repair produces a one-cycle pulse and advances a saturating counter.

A verification-only port XORs a mask into a stored codeword to emulate an upset.

Top module: `hamming_scrub_rf`

## Requirements
- R1: A word written at one clock edge can be read at any later edge. The read result (`rd_data`, `rd_corrected`) is registered and valid in the cycle after the edge that sampled `rd_en`. For an intact word it returns the written data with `rd_corrected` low.
- R2: A word with any one of its 7 codeword bits flipped reads back as the originally written data. `rd_corrected` is high only in the cycle after a read of such a word, and is low after any cycle without `rd_en`.
- R3: A read never changes the stored word. A second read of a word that still holds an upset flags it again.
- R4: The walker position `scrub_addr` is 0 after reset. It first advances `PERIOD` cycles after reset release and then every `PERIOD` cycles. It always moves to the next address, going from `DEPTH-1` back to 0.
- R5: When the walker leaves an address whose word has a non-zero syndrome, it writes the corrected codeword back. `scrub_fix` is high for exactly that one cycle, together with the new `scrub_addr`. Later reads of that word return `rd_corrected` low. Leaving an intact word gives no pulse.
- R6: `fix_count` rises by one with every `scrub_fix` pulse and stays unchanged otherwise. It holds at 2^`CNT_W`-1 and does not wrap.
- R7: A functional write that lands on the edge at which the walker checks the same address takes precedence. The walker's repair is dropped: no pulse, no count, and the written data is what reads back.
- R8: An injection XORs `inj_mask` into the stored codeword at `inj_addr`. A functional write to the same address at the same edge takes precedence, and the mask is then dropped. A walker repair at the address being injected is also dropped.
- R9: During and right after reset, every word holds data 0 with no error, `rd_data`, `rd_corrected`, `scrub_fix` and `fix_count` are 0, and `scrub_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Functional write strobe |
| wr_addr | input | $clog2(DEPTH) | Write address |
| wr_data | input | 4 | Data to encode and store |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_data | output | 4 | Corrected read data, one cycle after the read |
| rd_corrected | output | 1 | High when the word just read had a single-bit error |
| inj_en | input | 1 | Upset-injection strobe (verification only) |
| inj_addr | input | $clog2(DEPTH) | Injection address |
| inj_mask | input | 7 | Bits to flip in the stored codeword |
| scrub_fix | output | 1 | One-cycle pulse after a walker repair |
| scrub_addr | output | $clog2(DEPTH) | Next address the walker will check |
| fix_count | output | CNT_W | Saturating count of walker repairs |

## Verification
Each of the 16 data values is written and read back to confirm clean decoding. Each of the 7 codeword bits is then flipped in turn and the word is read twice. This tells data-bit flips apart from check-bit flips, and it separates correction on read from any modification on read.

A long stretch of constrained-random writes, reads and single-bit injections follows. Injections always go to the address the walker has just left. This lets the bench predict, for every walker step, whether a repair pulse must appear, and run the repair counter past its saturation point. Directed cases then place a write and an injection on the same edge, and a write on the exact edge of a walker visit to a corrupted word, to check each priority rule.

// File: rtl/hamming_scrub_rf.sv
module hamming_scrub_rf #(
  parameter int DEPTH  = 8,
  parameter int PERIOD = 16,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [3:0]               wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [3:0]               rd_data,
  output logic                     rd_corrected,
  input  logic                     inj_en,
  input  logic [$clog2(DEPTH)-1:0] inj_addr,
  input  logic [6:0]               inj_mask,
  output logic                     scrub_fix,
  output logic [$clog2(DEPTH)-1:0] scrub_addr,
  output logic [CNT_W-1:0]         fix_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // codeword bit k holds Hamming position k+1: checks at 1,2,4, data at 3,5,6,7
  function automatic logic [6:0] encode(input logic [3:0] d);
    logic [6:0] c;
    c[2] = d[0];
    c[4] = d[1];
    c[5] = d[2];
    c[6] = d[3];
    c[0] = d[0] ^ d[1] ^ d[3];
    c[1] = d[0] ^ d[2] ^ d[3];
    c[3] = d[1] ^ d[2] ^ d[3];
    return c;
  endfunction

  function automatic logic [2:0] syndrome(input logic [6:0] c);
    return {c[3] ^ c[4] ^ c[5] ^ c[6],
            c[1] ^ c[2] ^ c[5] ^ c[6],
            c[0] ^ c[2] ^ c[4] ^ c[6]};
  endfunction

  function automatic logic [6:0] repair(input logic [6:0] c);
    logic [6:0] r;
    logic [2:0] s;
    r = c;
    s = syndrome(c);
    if (s != 3'd0) r[s - 3'd1] = ~r[s - 3'd1];
    return r;
  endfunction

  function automatic logic [3:0] extract(input logic [6:0] c);
    return {c[6], c[5], c[4], c[2]};
  endfunction

  logic [6:0]    mem [DEPTH];
  logic [TW-1:0] tmr;
  logic          visit;
  logic [6:0]    scrub_word;
  logic [6:0]    rd_word;
  logic          scrub_wb;

  assign visit      = (tmr == TW'(PERIOD - 1));
  assign scrub_word = mem[scrub_addr];
  assign rd_word    = mem[rd_addr];
  assign scrub_wb   = visit && (syndrome(scrub_word) != 3'd0)
                      && !(wr_en && wr_addr == scrub_addr)
                      && !(inj_en && inj_addr == scrub_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && wr_addr == AW'(i))
          mem[i] <= encode(wr_data);
        else if (inj_en && inj_addr == AW'(i))
          mem[i] <= mem[i] ^ inj_mask;
        else if (scrub_wb && scrub_addr == AW'(i))
          mem[i] <= repair(scrub_word);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr        <= '0;
      scrub_addr <= '0;
      scrub_fix  <= 1'b0;
      fix_count  <= '0;
    end else begin
      scrub_fix <= scrub_wb;
      if (visit) begin
        tmr        <= '0;
        scrub_addr <= (scrub_addr == LAST) ? '0 : scrub_addr + 1'b1;
      end else begin
        tmr <= tmr + 1'b1;
      end
      if (scrub_wb && fix_count != '1) fix_count <= fix_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      rd_corrected <= 1'b0;
    end else begin
      rd_corrected <= rd_en && (syndrome(rd_word) != 3'd0);
      if (rd_en) rd_data <= extract(repair(rd_word));
    end
  end
endmodule

module hamming_scrub_rf_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_en,
  input logic                     rd_corrected,
  input logic                     scrub_fix,
  input logic [$clog2(DEPTH)-1:0] scrub_addr,
  input logic [CNT_W-1:0]         fix_count
);
  localparam int AW = $clog2(DEPTH);

  assert_flag_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_corrected |-> $past(rd_en));

  assert_walk_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_addr != $past(scrub_addr)) |->
      (scrub_addr == (($past(scrub_addr) == AW'(DEPTH - 1)) ? '0 : $past(scrub_addr) + 1'b1)));

  assert_fix_on_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_fix |-> (scrub_addr != $past(scrub_addr)));

  assert_count_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_fix |-> ((fix_count == $past(fix_count) + 1'b1) || ((&fix_count) && (&$past(fix_count)))));

  assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !scrub_fix |-> $stable(fix_count));
endmodule

bind hamming_scrub_rf hamming_scrub_rf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_corrected(rd_corrected),
  .scrub_fix(scrub_fix), .scrub_addr(scrub_addr), .fix_count(fix_count));

// File: tb/tb_hamming_scrub_rf.sv
module tb_hamming_scrub_rf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int PERIOD = 4;
  localparam int CNT_W  = 3;
  localparam int AW     = $clog2(DEPTH);
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, inj_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0, inj_addr = '0;
  logic [3:0] wr_data = '0;
  logic [6:0] inj_mask = '0;
  logic [3:0] rd_data;
  logic rd_corrected, scrub_fix;
  logic [AW-1:0] scrub_addr;
  logic [CNT_W-1:0] fix_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  hamming_scrub_rf #(.DEPTH(DEPTH), .PERIOD(PERIOD), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_corrected(rd_corrected),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .scrub_fix(scrub_fix), .scrub_addr(scrub_addr), .fix_count(fix_count));

  int checks = 0, fails = 0, pulses = 0, prev_sa = 0, since = 0;
  bit sa_changed = 0, done = 0;
  logic [3:0] mdata [DEPTH];
  bit dirty [DEPTH];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic int sat(input int n);
    return (n > MAXC) ? MAXC : n;
  endfunction

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/2);
    since++;
    sa_changed = 0;
    if (int'(scrub_addr) != prev_sa) begin
      chk(since == PERIOD, "R4", "visit spacing", since, PERIOD);
      chk(int'(scrub_addr) == (prev_sa + 1) % DEPTH, "R4", "next address", scrub_addr, (prev_sa + 1) % DEPTH);
      chk(scrub_fix == dirty[prev_sa], "R5", "fix pulse on visit", scrub_fix, dirty[prev_sa]);
      if (scrub_fix) pulses++;
      dirty[prev_sa] = 0;
      prev_sa = int'(scrub_addr);
      since = 0;
      sa_changed = 1;
    end else begin
      chk(scrub_fix == 1'b0, "R5", "no pulse between visits", scrub_fix, 0);
    end
    chk(int'(fix_count) == sat(pulses), "R6", "fix counter", fix_count, sat(pulses));
  endtask

  task automatic cyc(input bit we, input int wa, input logic [3:0] wd, input bit re, input int ra,
                     input bit ie, input int ia, input logic [6:0] im);
    logic [3:0] exp_d;
    bit exp_c;
    exp_d = mdata[ra];
    exp_c = dirty[ra];
    if (ie && !(we && wa == ia)) dirty[ia] = 1;
    if (we) begin mdata[wa] = wd; dirty[wa] = 0; end
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    rd_en = re; rd_addr = AW'(ra);
    inj_en = ie; inj_addr = AW'(ia); inj_mask = im;
    step();
    wr_en = 0; rd_en = 0; inj_en = 0;
    if (re) begin
      chk(rd_data == exp_d, exp_c ? "R2" : "R1", "read data", rd_data, exp_d);
      chk(rd_corrected == exp_c, exp_c ? "R3" : "R1", "read flag", rd_corrected, exp_c);
    end else begin
      chk(rd_corrected == 1'b0, "R2", "flag without read", rd_corrected, 0);
    end
  endtask

  task automatic idle();
    cyc(0, 0, 4'd0, 0, 0, 0, 0, 7'd0);
  endtask

  task automatic wait_step();
    do idle(); while (!sa_changed);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int t, c;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin mdata[i] = 4'd0; dirty[i] = 0; end
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    chk(rd_data == 0 && rd_corrected == 0, "R9", "read outputs in reset", rd_data, 0);
    chk(scrub_fix == 0 && fix_count == 0, "R9", "scrub outputs in reset", fix_count, 0);
    rst_n = 1;
    chk(scrub_addr == 0, "R9", "walker start", scrub_addr, 0);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 4'd0, 1, i, 0, 0, 7'd0);

    // R1: every data value round-trips cleanly
    for (int v = 0; v < 16; v++) begin
      cyc(1, v % DEPTH, 4'(v), 0, 0, 0, 0, 7'd0);
      cyc(0, 0, 4'd0, 1, v % DEPTH, 0, 0, 7'd0);
    end

    // R2/R3: each codeword bit flipped, read twice
    for (int b = 0; b < 7; b++) begin
      wait_step();
      t = (int'(scrub_addr) + DEPTH - 1) % DEPTH;
      cyc(1, t, 4'(b + 9), 0, 0, 0, 0, 7'd0);
      cyc(0, 0, 4'd0, 0, 0, 1, t, 7'(1 << b));
      cyc(0, 0, 4'd0, 1, t, 0, 0, 7'd0);
      cyc(0, 0, 4'd0, 1, t, 0, 0, 7'd0);
    end
    // R5: after a full walk every word reads clean
    repeat (DEPTH * PERIOD + 2) idle();
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 4'd0, 1, i, 0, 0, 7'd0);
    for (int i = 0; i < DEPTH; i++) chk(dirty[i] == 0, "R5", "model clean after walk", dirty[i], 0);

    // R8: write beats injection at the same edge
    wait_step();
    t = (int'(scrub_addr) + DEPTH - 1) % DEPTH;
    cyc(1, t, 4'hA, 0, 0, 1, t, 7'h10);
    cyc(0, 0, 4'd0, 1, t, 0, 0, 7'd0);
    chk(rd_corrected == 0, "R8", "write wins over inject", rd_corrected, 0);

    // R7: write on the visit edge cancels the repair
    wait_step();
    c = int'(scrub_addr);
    cyc(0, 0, 4'd0, 0, 0, 1, c, 7'h04);
    repeat (PERIOD - 2) idle();
    t = pulses;
    cyc(1, c, 4'h5, 0, 0, 0, 0, 7'd0);
    chk(sa_changed && scrub_fix == 0, "R7", "no repair when write collides", scrub_fix, 0);
    chk(pulses == t, "R7", "count unchanged", pulses, t);
    cyc(0, 0, 4'd0, 1, c, 0, 0, 7'd0);
    chk(rd_data == 4'h5 && rd_corrected == 0, "R7", "written data kept", rd_data, 5);

    // constrained random mix
    for (int n = 0; n < 2500; n++) begin
      bit we, re, ie;
      int wa, ra;
      we = ($urandom % 3) == 0;
      wa = $urandom % DEPTH;
      re = ($urandom % 2) == 0;
      ra = $urandom % DEPTH;
      t = (prev_sa + DEPTH - 1) % DEPTH;
      ie = (($urandom % 4) == 0) && !dirty[t] && !(we && wa == t);
      cyc(we, wa, 4'($urandom), re, ra, ie, t, 7'(1 << ($urandom % 7)));
    end
    chk(pulses > MAXC, "R6", "enough repairs to saturate", pulses, MAXC + 1);
    chk(int'(fix_count) == MAXC, "R6", "counter saturated", fix_count, MAXC);
    report();
  end
endmodule